// File: doc/BRIEF.md
# Two-Class Programmable Interrupt Controller

This block collects seventeen interrupt requests and turns them into two requests to a processor: an urgent (critical) line and an ordinary (non-critical) line. Seven requests arrive from package pins and are resynchronised to the block clock. Ten come from on-chip peripherals already in the clock domain. Software chooses, one source at a time, whether the source is sensed by level or by edge, which polarity counts as active, and which of the two lines it drives.

Software reads status, writes ones to clear latched edges, and masks sources with an enable word. For the critical line the block also picks one winner among the pending critical sources, using a programmable rank per source. It then forms a handler address from a programmable base plus the winner's index scaled by a fixed shift, so no polling is needed. The register port is a plain single-cycle write strobe with a combinational read.

Top module: `twoclass_irq_ctrl`

## Requirements
- R1: After reset every enable is 0, every source is non-critical, level-sensitive and active-high, status, masked status, base and vector all read 0, each rank field reads its own source index, and both request outputs are low.
- R2: In level mode a source's status bit equals its input XOR its polarity bit. Writing 1 to that bit through the status word leaves it unchanged while the corrected input stays 1.
- R3: In edge mode a status bit is set by a 0-to-1 change of the polarity-corrected input. It stays set until a 1 is written to it at the status word (offset 0), and writing 0 leaves it set.
- R4: Polarity bit 1 makes a source active-low: low level in level mode, falling edge in edge mode.
- R5: Source bits 0..6 are the pin inputs `ext_irq_i[6:0]`, seen in status two clocks after they change. Bits 7..16 are `int_irq_i[9:0]`, seen in status in the same cycle.
- R6: Masked status (offset 5) is status AND enable (offset 1). `irq_noncrit_o` is the OR of masked bits whose class bit (offset 2) is 0. `irq_crit_o` is the OR of masked bits whose class bit is 1.
- R7: Among pending critical sources the winner has the smallest 5-bit rank (offset 8+i for source i). On equal ranks the lower index wins.
- R8: The vector (`irq_vec_o` and offset 7) is base (offset 6) plus winner index shifted left by 4. It is 0 when no critical source is pending.
- R9: Register offsets are 0 status, 1 enable, 2 class, 3 edge-select, 4 polarity (1 = active-low), 5 masked status, 6 base and 7 vector. Offsets 3 and 4 read back what was written; unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | 7 | Asynchronous pin requests (sources 0..6) |
| int_irq_i | input | 10 | On-chip requests (sources 7..16) |
| reg_addr_i | input | 5 | Register word offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_crit_o | output | 1 | Critical request to the processor |
| irq_noncrit_o | output | 1 | Non-critical request to the processor |
| irq_vec_o | output | 32 | Critical handler address, 0 when idle |

## Verification
The bench goes after a clear written to an active level source: a design that honoured it would drop the request while the line is still asserted. It checks that changing polarity on an edge source counts as an edge when it flips the corrected input, since a design that missed this would lose or invent requests. It checks equal ranks, where a design with the wrong comparison would let the higher index win. It checks the exact sync latency of pin inputs, which a missing or extra stage shifts by a cycle. It also checks the all-idle vector, which a careless design leaves at the base instead of 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int ADDR_W      = 5;
   localparam int DATA_W      = 32;
   localparam int OFS_STAT    = 0;
   localparam int OFS_ENA     = 1;
   localparam int OFS_CLASS   = 2;
   localparam int OFS_EDGE    = 3;
   localparam int OFS_POL     = 4;
   localparam int OFS_MSTAT   = 5;
   localparam int OFS_BASE    = 6;
   localparam int OFS_VEC     = 7;
   localparam int OFS_RANK0   = 8;

   typedef enum logic [1:0] {
      SRC_LEVEL_HI = 2'b00,
      SRC_LEVEL_LO = 2'b01,
      SRC_EDGE_UP  = 2'b10,
      SRC_EDGE_DN  = 2'b11
   } src_mode_e;
endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic edge_sel_i,
   input  logic act_low_i,
   input  logic clr_i,
   output logic stat_o
);
   import irqc_pkg::*;

   logic      seen;
   logic      norm;
   logic      prev_q;
   logic      latch_q;
   src_mode_e mode;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign seen = raw_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
         end
         assign seen = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   assign mode = src_mode_e'({edge_sel_i, act_low_i});
   assign norm = seen ^ act_low_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q <= norm;
         if (!edge_sel_i)          latch_q <= 1'b0;
         else if (norm && !prev_q) latch_q <= 1'b1;
         else if (clr_i)           latch_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (mode)
         SRC_EDGE_UP, SRC_EDGE_DN: stat_o = latch_q;
         default:                  stat_o = norm;
      endcase
   end
endmodule

// File: rtl/irqc_rank_pick.sv
module irqc_rank_pick #(
   parameter int N      = 17,
   parameter int RANK_W = 5,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]             pend_i,
   input  logic [N-1:0][RANK_W-1:0] rank_i,
   output logic                     any_o,
   output logic [IDX_W-1:0]         idx_o
);
   logic [RANK_W-1:0] best;

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      best  = '1;
      for (int i = 0; i < N; i++) begin
         if (pend_i[i] && (!any_o || rank_i[i] < best)) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
            best  = rank_i[i];
         end
      end
   end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
   parameter int N      = 17,
   parameter int RANK_W = 5,
   localparam int AW    = irqc_pkg::ADDR_W,
   localparam int DW    = irqc_pkg::DATA_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [AW-1:0]            addr_i,
   input  logic                     wr_i,
   input  logic [DW-1:0]            wdata_i,
   input  logic [N-1:0]             stat_i,
   input  logic [DW-1:0]            vec_i,
   output logic [N-1:0]             ena_o,
   output logic [N-1:0]             cls_o,
   output logic [N-1:0]             edge_o,
   output logic [N-1:0]             pol_o,
   output logic [DW-1:0]            base_o,
   output logic [N-1:0][RANK_W-1:0] rank_o,
   output logic [N-1:0]             clr_o,
   output logic [DW-1:0]            rdata_o
);
   import irqc_pkg::*;

   localparam int RANK_END = OFS_RANK0 + N;

   logic [N-1:0] wsrc;
   int unsigned  a;

   assign wsrc  = wdata_i[N-1:0];
   assign a     = int'(addr_i);
   assign clr_o = (wr_i && a == OFS_STAT) ? wsrc : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_o  <= '0;
         cls_o  <= '0;
         edge_o <= '0;
         pol_o  <= '0;
         base_o <= '0;
         for (int i = 0; i < N; i++) rank_o[i] <= RANK_W'(i);
      end else if (wr_i) begin
         case (a)
            OFS_ENA:   ena_o  <= wsrc;
            OFS_CLASS: cls_o  <= wsrc;
            OFS_EDGE:  edge_o <= wsrc;
            OFS_POL:   pol_o  <= wsrc;
            OFS_BASE:  base_o <= wdata_i;
            default: begin
               for (int i = 0; i < N; i++)
                  if (a == OFS_RANK0 + i) rank_o[i] <= wdata_i[RANK_W-1:0];
            end
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      case (a)
         OFS_STAT:  rdata_o[N-1:0] = stat_i;
         OFS_ENA:   rdata_o[N-1:0] = ena_o;
         OFS_CLASS: rdata_o[N-1:0] = cls_o;
         OFS_EDGE:  rdata_o[N-1:0] = edge_o;
         OFS_POL:   rdata_o[N-1:0] = pol_o;
         OFS_MSTAT: rdata_o[N-1:0] = stat_i & ena_o;
         OFS_BASE:  rdata_o        = base_o;
         OFS_VEC:   rdata_o        = vec_i;
         default: begin
            if (a >= OFS_RANK0 && a < RANK_END)
               for (int i = 0; i < N; i++)
                  if (a == OFS_RANK0 + i) rdata_o[RANK_W-1:0] = rank_o[i];
         end
      endcase
   end
endmodule

// File: rtl/twoclass_irq_ctrl.sv
module twoclass_irq_ctrl #(
   parameter int NUM_EXT     = 7,
   parameter int NUM_INT     = 10,
   parameter int SYNC_STAGES = 2,
   parameter int RANK_W      = 5,
   parameter int VEC_SHIFT   = 4,
   localparam int NUM_SRC    = NUM_EXT + NUM_INT,
   localparam int IDX_W      = $clog2(NUM_SRC),
   localparam int AW         = irqc_pkg::ADDR_W,
   localparam int DW         = irqc_pkg::DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_irq_i,
   input  logic [NUM_INT-1:0] int_irq_i,
   input  logic [AW-1:0]      reg_addr_i,
   input  logic               reg_wr_i,
   input  logic [DW-1:0]      reg_wdata_i,
   output logic [DW-1:0]      reg_rdata_o,
   output logic               irq_crit_o,
   output logic               irq_noncrit_o,
   output logic [DW-1:0]      irq_vec_o
);
   import irqc_pkg::*;

   if (NUM_SRC > DW) $error("source count exceeds data width");
   if (OFS_RANK0 + NUM_SRC > (1 << AW)) $error("rank fields overflow the address space");
   if ((1 << RANK_W) < NUM_SRC) $error("rank width too small for unique reset ranks");
   if (SYNC_STAGES == 1) $error("a single sync stage is not allowed");
   if (VEC_SHIFT + IDX_W > DW) $error("vector shift too large");

   logic [NUM_SRC-1:0]             raw;
   logic [NUM_SRC-1:0]             stat_w;
   logic [NUM_SRC-1:0]             ena_q, cls_q, trig_q, pol_q, clr_vec;
   logic [NUM_SRC-1:0]             masked, pend_crit, pend_norm;
   logic [NUM_SRC-1:0][RANK_W-1:0] rank_q;
   logic [DW-1:0]                  base_q;
   logic                           win_any;
   logic [IDX_W-1:0]               win_idx;

   assign raw = {int_irq_i, ext_irq_i};

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      localparam int STAGES = (g < NUM_EXT) ? SYNC_STAGES : 0;
      irqc_src_cell #(.SYNC_STAGES(STAGES)) cell_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .raw_i      (raw[g]),
         .edge_sel_i (trig_q[g]),
         .act_low_i  (pol_q[g]),
         .clr_i      (clr_vec[g]),
         .stat_o     (stat_w[g])
      );
   end

   irqc_regs #(.N(NUM_SRC), .RANK_W(RANK_W)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (reg_addr_i),
      .wr_i    (reg_wr_i),
      .wdata_i (reg_wdata_i),
      .stat_i  (stat_w),
      .vec_i   (irq_vec_o),
      .ena_o   (ena_q),
      .cls_o   (cls_q),
      .edge_o  (trig_q),
      .pol_o   (pol_q),
      .base_o  (base_q),
      .rank_o  (rank_q),
      .clr_o   (clr_vec),
      .rdata_o (reg_rdata_o)
   );

   assign masked    = stat_w & ena_q;
   assign pend_crit = masked & cls_q;
   assign pend_norm = masked & ~cls_q;

   irqc_rank_pick #(.N(NUM_SRC), .RANK_W(RANK_W)) pick_i (
      .pend_i (pend_crit),
      .rank_i (rank_q),
      .any_o  (win_any),
      .idx_o  (win_idx)
   );

   assign irq_crit_o    = |pend_crit;
   assign irq_noncrit_o = |pend_norm;
   assign irq_vec_o     = win_any ? (base_q + (DW'(win_idx) << VEC_SHIFT)) : '0;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int N     = 17,
   parameter int IDX_W = 5,
   parameter int DW    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N-1:0]     stat,
   input logic [N-1:0]     trig,
   input logic [N-1:0]     ena,
   input logic [N-1:0]     clr,
   input logic [N-1:0]     pend_crit,
   input logic [IDX_W-1:0] win_idx,
   input logic             crit,
   input logic             noncrit,
   input logic [DW-1:0]    vec
);
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!crit && !noncrit && vec == '0));

   a_r3_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(stat & trig & ~clr)) & trig & ~stat) == '0));

   a_r6_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
      (ena == '0) |-> (!crit && !noncrit));

   a_r7_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
      crit |-> pend_crit[win_idx]);

   a_r8_vec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !crit |-> (vec == '0));
endmodule

bind twoclass_irq_ctrl irqc_checker #(.N(NUM_SRC), .IDX_W(IDX_W), .DW(DW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .stat      (stat_w),
   .trig      (trig_q),
   .ena       (ena_q),
   .clr       (clr_vec),
   .pend_crit (pend_crit),
   .win_idx   (win_idx),
   .crit      (irq_crit_o),
   .noncrit   (irq_noncrit_o),
   .vec       (irq_vec_o)
);

// File: tb/twoclass_irq_ctrl_tb_top.sv
module twoclass_irq_ctrl_tb_top;
   localparam int NS = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  ext_irq = '0;
   logic [9:0]  int_irq = '0;
   logic [4:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        crit, noncrit;
   logic [31:0] vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [NS-1:0] m_trig, m_pol, m_ena, m_cls, m_latch, m_prev;
   logic [31:0]   m_base;
   logic [4:0]    m_rank [NS];

   always #2ns clk = ~clk;

   twoclass_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .int_irq_i(int_irq),
      .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .irq_crit_o(crit), .irq_noncrit_o(noncrit), .irq_vec_o(vec)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wreg(input int a, input logic [31:0] d);
      @(negedge clk); addr = 5'(a); wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input int a, output logic [31:0] d);
      @(negedge clk); addr = 5'(a); #1ns; d = rdata;
   endtask

   function automatic logic [NS-1:0] f_norm();
      return {int_irq, ext_irq} ^ m_pol;
   endfunction

   function automatic logic [NS-1:0] f_stat();
      return (m_trig & m_latch) | (~m_trig & f_norm());
   endfunction

   function automatic logic [31:0] f_vec();
      logic [NS-1:0] p;
      int best;
      int idx;
      p = f_stat() & m_ena & m_cls;
      best = 99; idx = -1;
      for (int i = 0; i < NS; i++)
         if (p[i] && int'(m_rank[i]) < best) begin best = int'(m_rank[i]); idx = i; end
      return (idx < 0) ? 32'h0 : m_base + (32'(idx) << 4);
   endfunction

   task automatic settle();
      logic [NS-1:0] n;
      repeat (5) @(negedge clk);
      n = f_norm();
      m_latch = m_trig & (m_latch | (n & ~m_prev));
      m_prev  = n;
   endtask

   task automatic check_all();
      logic [31:0] d;
      logic [NS-1:0] s;
      s = f_stat();
      rreg(0, d); chk("R2/R3/R4 status", d, 32'(s));
      rreg(5, d); chk("R6 masked status", d, 32'(s & m_ena));
      rreg(7, d); chk("R8 vector reg", d, f_vec());
      chk("R8 vector port", vec, f_vec());
      chk("R6 crit line", 32'(crit), 32'(|(s & m_ena & m_cls)));
      chk("R6 noncrit line", 32'(noncrit), 32'(|(s & m_ena & ~m_cls)));
   endtask

   initial begin
      #800000ns;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd1357));
      m_trig = '0; m_pol = '0; m_ena = '0; m_cls = '0; m_latch = '0; m_prev = '0;
      m_base = '0;
      for (int i = 0; i < NS; i++) m_rank[i] = 5'(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R9 map
      for (int a = 0; a < 8; a++) begin rreg(a, d); chk("R1 reset reg", d, 32'h0); end
      for (int i = 0; i < NS; i++) begin rreg(8 + i, d); chk("R1 reset rank", d, 32'(i)); end
      chk("R1 crit low", 32'(crit), 0);
      chk("R1 noncrit low", 32'(noncrit), 0);
      rreg(30, d); chk("R9 unused offset", d, 32'h0);

      // R5 pin sync latency vs internal
      @(negedge clk); addr = 5'd0; ext_irq[0] = 1'b1; #1ns;
      chk("R5 pin cycle0", 32'(rdata[0]), 0);
      @(negedge clk); #1ns; chk("R5 pin cycle1", 32'(rdata[0]), 0);
      @(negedge clk); #1ns; chk("R5 pin cycle2", 32'(rdata[0]), 1);
      @(negedge clk); int_irq[0] = 1'b1; #1ns; chk("R5 internal same cycle", 32'(rdata[7]), 1);
      settle(); check_all();

      // R2 clear ignored on active level source
      wreg(0, 32'h1_FFFF); settle();
      rreg(0, d); chk("R2 w1c ignored while active", 32'(d[0]), 1);

      // R3 edge latch holds, write 0 no effect, write 1 clears
      wreg(3, 32'h2); m_trig = 17'h2; settle();
      ext_irq[1] = 1'b1; settle();
      ext_irq[1] = 1'b0; settle();
      rreg(0, d); chk("R3 edge held after input drop", 32'(d[1]), 1);
      wreg(0, 32'h0); settle();
      rreg(0, d); chk("R3 write 0 keeps", 32'(d[1]), 1);
      wreg(0, 32'h2); m_latch[1] = 1'b0; settle();
      rreg(0, d); chk("R3 write 1 clears", 32'(d[1]), 0);

      // R4 falling edge in active-low edge mode
      wreg(4, 32'h2); m_pol = 17'h2; settle();
      rreg(0, d); chk("R4 pol flip counts as edge", 32'(d[1]), 1);
      wreg(0, 32'h2); m_latch[1] = 1'b0; settle();
      ext_irq[1] = 1'b1; settle(); ext_irq[1] = 1'b0; settle();
      rreg(0, d); chk("R4 falling edge latched", 32'(d[1]), 1);

      // R7 tie: sources 0 and 7 critical at equal rank
      wreg(2, 32'h1_FFFF); m_cls = '1;
      wreg(1, 32'h81); m_ena = 17'h81;
      wreg(8 + 7, 32'd3); m_rank[7] = 5'd3;
      wreg(8 + 0, 32'd3); m_rank[0] = 5'd3;
      wreg(6, 32'h1000); m_base = 32'h1000;
      settle();
      chk("R7 tie lower index", vec, 32'h1000);
      wreg(8 + 7, 32'd1); m_rank[7] = 5'd1; settle();
      chk("R7 lower rank wins", vec, 32'h1000 + (7 << 4));
      rreg(3, d); chk("R9 edge readback", d, 32'h2);
      rreg(4, d); chk("R9 pol readback", d, 32'h2);
      check_all();

      // constrained random rounds
      for (int r = 0; r < 60; r++) begin
         logic [NS-1:0] v;
         v = NS'($urandom); wreg(3, 32'(v)); m_trig = v; settle(); check_all();
         v = NS'($urandom); wreg(4, 32'(v)); m_pol = v; settle(); check_all();
         v = NS'($urandom); wreg(1, 32'(v)); m_ena = v;
         v = NS'($urandom); wreg(2, 32'(v)); m_cls = v;
         m_base = $urandom & 32'hFFFF_FF00; wreg(6, m_base);
         for (int k = 0; k < 4; k++) begin
            int s;
            s = int'($urandom % NS);
            m_rank[s] = 5'($urandom % 4);
            wreg(8 + s, 32'(m_rank[s]));
         end
         ext_irq = 7'($urandom); int_irq = 10'($urandom); settle(); check_all();
         v = NS'($urandom); wreg(0, 32'(v)); m_latch = m_latch & ~v; settle(); check_all();
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule